// File: doc/BRIEF.md
# Receive FIFO pause flow controller

This block watches the byte occupancy of a receive FIFO and asks a frame generator to send flow-control PAUSE frames. When the FIFO becomes congested it requests an XOFF carrying a programmed quanta value. While the congestion lasts, it repeats the XOFF at a programmed interval. Once the FIFO drains, it requests an XON, which is a pause with quanta zero.

It also honours PAUSE frames that the receiver has decoded. Each accepted frame loads a countdown. The transmitter is held off while the countdown is non-zero. The frame generator sees at most one request at a time, and it acknowledges that request. Any congestion events that occur while a request is outstanding collapse into a single follow-up request.

Top module: `pause_flow_ctrl`

## Requirements
- R1: The occupancy is taken in 8-byte units as floor(fifo_level_i/8). When the block is not congested and the unit count is strictly greater than hwm_i (non-zero), the block becomes congested. An XOFF request (req_vld_o=1, req_xoff_o=1) appears one cycle later.
- R2: While congested, a unit count strictly below lwm_i ends the congestion and raises an XON request (req_xoff_o=0) one cycle later.
- R3: While an XOFF request is presented, req_quanta_o equals quanta_i. While an XON request is presented, req_quanta_o is 0.
- R4: When hwm_i is 0, no congestion is detected, an existing congestion is cleared, and no new request is raised.
- R5: While congested and refresh_i is non-zero, a further XOFF event occurs every refresh_i cycles, counted from the cycle in which congestion began. When refresh_i is 0, no repeat is sent.
- R6: A request stays presented, with the same kind, until req_ack_i is sampled high. The clock edge that samples the acknowledge retires the request.
- R7: Events that arrive while a request is outstanding are merged, and the latest one wins. The merged request is presented in the cycle after the acknowledge. If no event is waiting, req_vld_o drops.
- R8: A received pause (rx_pause_vld_i with rx_pause_en_i=1) loads tx_pause_cnt_o with rx_pause_quanta_i one cycle later. The count then decreases by one per cycle down to 0. tx_inhibit_o is high exactly while the count is non-zero.
- R9: A new received pause reloads the count even while it is running. A quanta of 0 clears the count at once.
- R10: When rx_pause_en_i is 0, received pauses have no effect on tx_pause_cnt_o or tx_inhibit_o.
- R11: After reset, req_vld_o, tx_inhibit_o and tx_pause_cnt_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_level_i | input | LVL_W | Receive FIFO occupancy in bytes |
| hwm_i | input | WM_W | High watermark in 8-byte units; 0 disables generation |
| lwm_i | input | WM_W | Low watermark in 8-byte units |
| quanta_i | input | QNT_W | Quanta placed in XOFF requests |
| refresh_i | input | TMR_W | XOFF repeat interval in cycles; 0 disables |
| rx_pause_en_i | input | 1 | Allow received pauses to inhibit transmit |
| rx_pause_vld_i | input | 1 | A pause frame was received |
| rx_pause_quanta_i | input | QNT_W | Quanta of the received pause |
| req_ack_i | input | 1 | Frame generator accepts the presented request |
| req_vld_o | output | 1 | Request presented |
| req_xoff_o | output | 1 | 1 = XOFF, 0 = XON |
| req_quanta_o | output | QNT_W | Quanta for the requested frame |
| tx_inhibit_o | output | 1 | Transmit held off |
| tx_pause_cnt_o | output | QNT_W | Remaining pause count |

## Verification
Every result is registered once. A level change, an acknowledge or a received pause therefore shows on the outputs after the next rising edge, and a refresh repeat is due exactly refresh_i edges after congestion begins. The bench drives inputs on the falling edge and samples on the following falling edge, so each check sees the state of the edge that the stimulus fed. The refresh spacing is checked by counting edges from the first XOFF, and the countdown is checked value by value.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef struct packed {
    logic vld;
    logic xoff;
  } pfc_evt_t;
endpackage

// File: rtl/pfc_refresh_tmr.sv
module pfc_refresh_tmr #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [TMR_W-1:0] period_i,
  output logic             hit_o
);
  logic [TMR_W-1:0] tmr_q;

  assign hit_o = active_i && (period_i != '0) && (tmr_q == TMR_W'(period_i - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (!active_i || hit_o) tmr_q <= '0;
    else                        tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/pfc_level_mon.sv
module pfc_level_mon
  import pfc_pkg::*;
#(
  parameter int LVL_W      = 18,
  parameter int WM_W       = 16,
  parameter int TMR_W      = 16,
  parameter int UNIT_SHIFT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [WM_W-1:0]  hwm_i,
  input  logic [WM_W-1:0]  lwm_i,
  input  logic [TMR_W-1:0] refresh_i,
  output pfc_evt_t         evt_o
);
  localparam int CMP_W = (LVL_W > WM_W) ? LVL_W : WM_W;

  logic [CMP_W-1:0] units, hwm_x, lwm_x;
  logic cong_q, cong_d, gen_en, above, below, refresh_hit;

  assign units  = CMP_W'(fifo_level_i >> UNIT_SHIFT);
  assign hwm_x  = CMP_W'(hwm_i);
  assign lwm_x  = CMP_W'(lwm_i);
  assign gen_en = |hwm_i;
  assign above  = units > hwm_x;
  assign below  = units < lwm_x;

  pfc_refresh_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(cong_q && gen_en && !below),
    .period_i(refresh_i),
    .hit_o   (refresh_hit)
  );

  always_comb begin
    evt_o  = '0;
    cong_d = cong_q;
    if (!gen_en) begin
      cong_d = 1'b0;
    end else if (!cong_q) begin
      if (above) begin
        cong_d = 1'b1;
        evt_o  = '{vld: 1'b1, xoff: 1'b1};
      end
    end else if (below) begin
      cong_d = 1'b0;
      evt_o  = '{vld: 1'b1, xoff: 1'b0};
    end else if (refresh_hit) begin
      evt_o  = '{vld: 1'b1, xoff: 1'b1};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cong_q <= 1'b0;
    else         cong_q <= cong_d;
  end
endmodule

// File: rtl/pfc_req_slot.sv
module pfc_req_slot
  import pfc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pfc_evt_t evt_i,
  input  logic     ack_i,
  output logic     vld_o,
  output logic     xoff_o
);
  pfc_evt_t out_q, want_q;

  assign vld_o  = out_q.vld;
  assign xoff_o = out_q.xoff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      want_q <= '0;
    end else if (!out_q.vld) begin
      out_q  <= evt_i;
    end else if (ack_i) begin
      // newest event beats an older merged one
      if (evt_i.vld)       out_q <= evt_i;
      else if (want_q.vld) out_q <= want_q;
      else                 out_q <= '0;
      want_q <= '0;
    end else if (evt_i.vld) begin
      want_q <= evt_i;
    end
  end
endmodule

// File: rtl/pfc_rx_inhibit.sv
module pfc_rx_inhibit #(
  parameter int QNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pause_vld_i,
  input  logic [QNT_W-1:0] pause_quanta_i,
  output logic [QNT_W-1:0] cnt_o,
  output logic             inhibit_o
);
  logic [QNT_W-1:0] cnt_q;

  assign cnt_o     = cnt_q;
  assign inhibit_o = |cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (en_i && pause_vld_i) cnt_q <= pause_quanta_i;
    else if (|cnt_q)              cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int LVL_W = 18,
  parameter int WM_W  = 16,
  parameter int QNT_W = 16,
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [WM_W-1:0]  hwm_i,
  input  logic [WM_W-1:0]  lwm_i,
  input  logic [QNT_W-1:0] quanta_i,
  input  logic [TMR_W-1:0] refresh_i,
  input  logic             rx_pause_en_i,
  input  logic             rx_pause_vld_i,
  input  logic [QNT_W-1:0] rx_pause_quanta_i,
  input  logic             req_ack_i,
  output logic             req_vld_o,
  output logic             req_xoff_o,
  output logic [QNT_W-1:0] req_quanta_o,
  output logic             tx_inhibit_o,
  output logic [QNT_W-1:0] tx_pause_cnt_o
);
  localparam int UNIT_SHIFT = 3;

  pfc_evt_t evt;

  pfc_level_mon #(
    .LVL_W(LVL_W), .WM_W(WM_W), .TMR_W(TMR_W), .UNIT_SHIFT(UNIT_SHIFT)
  ) u_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_level_i(fifo_level_i),
    .hwm_i       (hwm_i),
    .lwm_i       (lwm_i),
    .refresh_i   (refresh_i),
    .evt_o       (evt)
  );

  pfc_req_slot u_slot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .ack_i (req_ack_i),
    .vld_o (req_vld_o),
    .xoff_o(req_xoff_o)
  );

  assign req_quanta_o = (req_vld_o && req_xoff_o) ? quanta_i : '0;

  pfc_rx_inhibit #(.QNT_W(QNT_W)) u_inh (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (rx_pause_en_i),
    .pause_vld_i   (rx_pause_vld_i),
    .pause_quanta_i(rx_pause_quanta_i),
    .cnt_o         (tx_pause_cnt_o),
    .inhibit_o     (tx_inhibit_o)
  );
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int WM_W  = 16,
  parameter int QNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WM_W-1:0]  hwm_i,
  input logic             rx_pause_en_i,
  input logic             rx_pause_vld_i,
  input logic [QNT_W-1:0] rx_pause_quanta_i,
  input logic             req_ack_i,
  input logic             req_vld_o,
  input logic             req_xoff_o,
  input logic [QNT_W-1:0] req_quanta_o,
  input logic             tx_inhibit_o,
  input logic [QNT_W-1:0] tx_pause_cnt_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_o && !req_ack_i) |=> (req_vld_o && $stable(req_xoff_o))); // R6

  AST_XON_ZERO_QUANTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_o && !req_xoff_o) |-> (req_quanta_o == '0)); // R3

  AST_GEN_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hwm_i == '0 && !req_vld_o) |=> !req_vld_o); // R4

  AST_PAUSE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pause_en_i && rx_pause_vld_i) |=> (tx_pause_cnt_o == $past(rx_pause_quanta_i))); // R9

  AST_CNT_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pause_cnt_o != '0 && !(rx_pause_en_i && rx_pause_vld_i))
      |=> (tx_pause_cnt_o == $past(tx_pause_cnt_o) - 1'b1)); // R8

  AST_IDLE_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pause_cnt_o == '0 && !(rx_pause_en_i && rx_pause_vld_i)) |=> !tx_inhibit_o); // R10
endmodule

bind pause_flow_ctrl pfc_checker #(.WM_W(WM_W), .QNT_W(QNT_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .hwm_i            (hwm_i),
  .rx_pause_en_i    (rx_pause_en_i),
  .rx_pause_vld_i   (rx_pause_vld_i),
  .rx_pause_quanta_i(rx_pause_quanta_i),
  .req_ack_i        (req_ack_i),
  .req_vld_o        (req_vld_o),
  .req_xoff_o       (req_xoff_o),
  .req_quanta_o     (req_quanta_o),
  .tx_inhibit_o     (tx_inhibit_o),
  .tx_pause_cnt_o   (tx_pause_cnt_o)
);

// File: tb/pause_flow_ctrl_test.sv
`timescale 1ns/1ps
module pause_flow_ctrl_test;
  localparam int LVL_W = 18, WM_W = 16, QNT_W = 16, TMR_W = 16;
  localparam logic [QNT_W-1:0] QNT = 16'h1234;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LVL_W-1:0] level = '0;
  logic [WM_W-1:0]  hwm = 16'd10, lwm = 16'd4;
  logic [TMR_W-1:0] refresh = '0;
  logic rx_en = 1'b0, rx_vld = 1'b0, ack = 1'b0;
  logic [QNT_W-1:0] rx_q = '0;
  logic req_vld, req_xoff, inhibit;
  logic [QNT_W-1:0] req_q, cnt;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pause_flow_ctrl #(.LVL_W(LVL_W), .WM_W(WM_W), .QNT_W(QNT_W), .TMR_W(TMR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_level_i(level), .hwm_i(hwm), .lwm_i(lwm),
    .quanta_i(QNT), .refresh_i(refresh), .rx_pause_en_i(rx_en),
    .rx_pause_vld_i(rx_vld), .rx_pause_quanta_i(rx_q), .req_ack_i(ack),
    .req_vld_o(req_vld), .req_xoff_o(req_xoff), .req_quanta_o(req_q),
    .tx_inhibit_o(inhibit), .tx_pause_cnt_o(cnt));

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic             ack;
    logic             vld;
    logic             xoff;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{18'd0,   1'b0, 1'b0, 1'b0},  // idle
    '{18'd80,  1'b0, 1'b0, 1'b0},  // R1 10 units, not above
    '{18'd88,  1'b0, 1'b1, 1'b1},  // R1 11 units -> XOFF
    '{18'd88,  1'b0, 1'b1, 1'b1},  // R6 held
    '{18'd88,  1'b1, 1'b0, 1'b0},  // R6 retired
    '{18'd40,  1'b0, 1'b0, 1'b0},  // R2 5 units, not below
    '{18'd24,  1'b0, 1'b1, 1'b0},  // R2 3 units -> XON
    '{18'd100, 1'b0, 1'b1, 1'b0},  // R7 XOFF merged behind XON
    '{18'd100, 1'b1, 1'b1, 1'b1},  // R7 merged XOFF follows ack
    '{18'd100, 1'b1, 1'b0, 1'b0},
    '{18'd0,   1'b0, 1'b1, 1'b0},  // R2
    '{18'd0,   1'b1, 1'b0, 1'b0},
    '{18'd100, 1'b0, 1'b1, 1'b1},  // R1
    '{18'd0,   1'b0, 1'b1, 1'b1},  // R7 XON waits
    '{18'd100, 1'b0, 1'b1, 1'b1},  // R7 XOFF replaces waiting XON
    '{18'd100, 1'b1, 1'b1, 1'b1},  // R7 single merged XOFF
    '{18'd100, 1'b1, 1'b0, 1'b0},  // R7 nothing more waiting
    '{18'd0,   1'b0, 1'b1, 1'b0},
    '{18'd0,   1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_req(input string req, input logic v, input logic x);
    chk(req, {31'd0, req_vld}, {31'd0, v});
    if (v) begin
      chk(req, {31'd0, req_xoff}, {31'd0, x});
      chk({req, " R3"}, {16'd0, req_q}, x ? {16'd0, QNT} : 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {31'd0, req_vld}, 32'd0);
    chk("R11", {31'd0, inhibit}, 32'd0);
    chk("R11", {16'd0, cnt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      level = VEC[i].lvl;
      ack   = VEC[i].ack;
      tick();
      chk_req($sformatf("R1/R2/R6/R7 row %0d", i), VEC[i].vld, VEC[i].xoff);
    end
    ack = 1'b0;

    // R4: zero high watermark suppresses generation
    hwm = '0; level = 18'd2000;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R4", {31'd0, req_vld}, 32'd0);
    end
    level = '0; hwm = 16'd10;
    tick();

    // R5: refresh every 5 cycles while congested
    refresh = 16'd5; level = 18'd100;
    tick();
    chk_req("R5 first", 1'b1, 1'b1);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R5 retired", {31'd0, req_vld}, 32'd0);
    for (int k = 2; k <= 4; k++) begin
      tick();
      chk($sformatf("R5 quiet %0d", k), {31'd0, req_vld}, 32'd0);
    end
    tick();
    chk_req("R5 repeat", 1'b1, 1'b1);
    ack = 1'b1; level = '0; tick(); ack = 1'b0;
    chk_req("R2 after refresh", 1'b1, 1'b0);
    ack = 1'b1; tick(); ack = 1'b0;
    // R5 refresh 0: no repeat
    refresh = '0; level = 18'd100;
    tick();
    ack = 1'b1; tick(); ack = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick();
      chk("R5 off", {31'd0, req_vld}, 32'd0);
    end
    level = '0; tick(); ack = 1'b1; tick(); ack = 1'b0;

    // R8 countdown
    rx_en = 1'b1; rx_vld = 1'b1; rx_q = 16'd3;
    tick(); rx_vld = 1'b0;
    chk("R8 load", {16'd0, cnt}, 32'd3);
    chk("R8 inhibit", {31'd0, inhibit}, 32'd1);
    tick(); chk("R8 dec", {16'd0, cnt}, 32'd2);
    tick(); chk("R8 dec", {16'd0, cnt}, 32'd1);
    tick(); chk("R8 zero", {16'd0, cnt}, 32'd0);
    chk("R8 release", {31'd0, inhibit}, 32'd0);
    // R9 reload and clear
    rx_vld = 1'b1; rx_q = 16'd10; tick(); rx_vld = 1'b0;
    tick(); tick();
    chk("R9 run", {16'd0, cnt}, 32'd8);
    rx_vld = 1'b1; rx_q = 16'd20; tick(); rx_vld = 1'b0;
    chk("R9 reload", {16'd0, cnt}, 32'd20);
    rx_vld = 1'b1; rx_q = 16'd0; tick(); rx_vld = 1'b0;
    chk("R9 clear", {16'd0, cnt}, 32'd0);
    chk("R9 clear inhibit", {31'd0, inhibit}, 32'd0);
    // R10 disabled
    rx_en = 1'b0; rx_vld = 1'b1; rx_q = 16'd7; tick(); rx_vld = 1'b0;
    chk("R10 cnt", {16'd0, cnt}, 32'd0);
    chk("R10 inhibit", {31'd0, inhibit}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule